// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 level-sensitive request lines, one per peripheral, and offers the processor a single vector number for the most urgent request that is both pending and enabled. A peripheral with several internal interrupt flags ORs them onto its one line. Each line carries a 2-bit priority, where 0 is the most urgent and 3 the least. Software can make any line pending by writing a set mask, whether or not its hardware line is raised.

The processor takes a presented vector by pulsing `ack` and signals completion with `eos`. Each acknowledge records the line and its priority on a four-entry stack of active service levels. The top of that stack sets the mask level. A request is offered only if its priority value is strictly below the mask, so only a more urgent request can preempt the one in service. When service ends, the stack pops and the previous level returns. A line that is still held high then becomes pending again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all lines are disabled, nothing is pending, every priority is 0, the stack is empty, `mask_lvl` reads 4 (idle) and `irq_req` is 0.
- R2: A line held high sets its pending bit at the next clock edge, even while the line is disabled. A pending line is offered only while its enable bit is 1. `en_wr` loads all enable bits from `en_wdata`, where bit i enables line i.
- R3: Among lines that are pending, enabled and not masked, the smallest priority value wins. Among equal priorities the lowest line number wins. `irq_vec` gives the line number and `irq_prio` gives its priority.
- R4: A candidate is offered only when its priority value is strictly less than `mask_lvl`. A request at or above the level in service stays hidden.
- R5: `sw_set_wr` sets the pending bit of every line whose bit is 1 in `sw_set_mask`.
- R6: When `ack` is high, `irq_req` is 1 and `eos` is 0, the offered line's pending bit clears and its line number and priority are pushed onto the stack. At the next edge `mask_lvl` equals that priority. The line cannot become pending from its hardware input while it is in service.
- R7: `eos` pops the stack and restores the mask level of the entry below, or 4 when the stack empties. `eos` on an empty stack has no effect.
- R8: A line whose input is still high when its service ends becomes pending again one clock edge after the edge that pops it.
- R9: `ack` while `irq_req` is 0 has no effect. When `ack` and `eos` are high in the same cycle, only `eos` acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level request lines, one per peripheral |
| en_wr | input | 1 | Load the enable bits |
| en_wdata | input | 32 | New enable bits |
| sw_set_wr | input | 1 | Apply the software pending-set mask |
| sw_set_mask | input | 32 | Lines to make pending |
| prio_wr | input | 1 | Write one line's priority |
| prio_sel | input | 5 | Line whose priority is written |
| prio_wdata | input | 2 | Priority value, 0 = most urgent |
| ack | input | 1 | Processor takes the offered vector |
| eos | input | 1 | End of service of the top stack entry |
| irq_req | output | 1 | A vector is being offered |
| irq_vec | output | 5 | Offered line number |
| irq_prio | output | 2 | Priority of the offered line |
| mask_lvl | output | 3 | Current service level, 4 when idle |

## Verification
Every result shows at the outputs one clock edge after the stimulus that causes it. A raised line, a software set or an enable write changes `irq_req`, `irq_vec` and `irq_prio` after the next edge. An acknowledge or an end-of-service changes `mask_lvl` after the edge on which it is sampled. The one exception is re-pending after service (R8), which shows only after a second edge. The bench drives inputs 2 ns after a rising edge and samples right after the following rising edge. In the nested sequence it checks the outputs separately after the pop edge and after the edge that follows, which confirms the one-cycle gap before the line is offered again.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_LINES = 32,
  parameter int PRIO_W  = 2,
  parameter int DEPTH   = 4,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               en_wr,
  input  logic [N_LINES-1:0] en_wdata,
  input  logic               sw_set_wr,
  input  logic [N_LINES-1:0] sw_set_mask,
  input  logic               prio_wr,
  input  logic [IDX_W-1:0]   prio_sel,
  input  logic [PRIO_W-1:0]  prio_wdata,
  input  logic               ack,
  input  logic               eos,
  output logic               irq_req,
  output logic [IDX_W-1:0]   irq_vec,
  output logic [PRIO_W-1:0]  irq_prio,
  output logic [PRIO_W:0]    mask_lvl
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int STK_W = $clog2(DEPTH);
  localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic [N_LINES-1:0] en_q, pend_q, inserv_q, cand;
  logic [PRIO_W-1:0]  prio_q [N_LINES];
  logic [IDX_W-1:0]   stk_vec [DEPTH];
  logic [PRIO_W-1:0]  stk_pri [DEPTH];
  logic [SP_W-1:0]    sp_q, top;
  logic               found, take, pop;
  logic [IDX_W-1:0]   best_i;
  logic [PRIO_W-1:0]  best_p;

  assign cand = pend_q & en_q;

  always_comb begin
    found  = 1'b0;
    best_i = '0;
    best_p = '1;
    for (int i = 0; i < N_LINES; i++)
      if (cand[i] && (!found || prio_q[i] < best_p)) begin
        found  = 1'b1;
        best_i = IDX_W'(i);
        best_p = prio_q[i];
      end
  end

  assign top      = sp_q - SP_W'(1);
  assign mask_lvl = (sp_q == '0) ? IDLE : {1'b0, stk_pri[top[STK_W-1:0]]};
  assign irq_req  = found && ({1'b0, best_p} < mask_lvl);
  assign irq_vec  = best_i;
  assign irq_prio = best_p;
  assign take     = ack && irq_req && !eos && (sp_q < SP_W'(DEPTH));
  assign pop      = eos && (sp_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_q   <= '0;
      inserv_q <= '0;
      sp_q     <= '0;
      for (int i = 0; i < N_LINES; i++) prio_q[i] <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        stk_vec[d] <= '0;
        stk_pri[d] <= '0;
      end
    end else begin
      if (en_wr) en_q <= en_wdata;
      if (prio_wr) prio_q[prio_sel] <= prio_wdata;
      pend_q <= (pend_q | (irq_in & ~inserv_q) | (sw_set_wr ? sw_set_mask : '0))
                & ~(take ? (N_LINES'(1) << best_i) : '0);
      if (take) begin
        inserv_q[best_i]             <= 1'b1;
        stk_vec[sp_q[STK_W-1:0]]     <= best_i;
        stk_pri[sp_q[STK_W-1:0]]     <= best_p;
        sp_q                         <= sp_q + SP_W'(1);
      end else if (pop) begin
        inserv_q[stk_vec[top[STK_W-1:0]]] <= 1'b0;
        sp_q                              <= top;
      end
    end
  end

  // R4: an offered vector is always more urgent than the level in service
  a_r4_mask_strict: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ({1'b0, irq_prio} < mask_lvl));

  // R6: an acknowledge raises the service level to the taken priority
  a_r6_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !eos) |=> (mask_lvl == {1'b0, $past(irq_prio)}));

  // R6: the taken line is not offered again right after its acknowledge
  a_r6_no_reoffer: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !eos) |=> !(irq_req && irq_vec == $past(irq_vec)));

  // R9: an acknowledge with nothing offered leaves the level unchanged
  a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req && !eos) |=> $stable(mask_lvl));

  // R7: end-of-service on an empty stack keeps the idle level
  a_r7_empty_eos: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && mask_lvl == IDLE) |=> (mask_lvl == IDLE));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_in = '0, en_wdata = '0, sw_set_mask = '0;
  logic        en_wr = 0, sw_set_wr = 0, prio_wr = 0, ack = 0, eos = 0;
  logic [4:0]  prio_sel = '0;
  logic [1:0]  prio_wdata = '0;
  logic        irq_req;
  logic [4:0]  irq_vec;
  logic [1:0]  irq_prio;
  logic [2:0]  mask_lvl;
  int total = 0, bad = 0;
  bit done = 0;

  prio_irq_ctrl i_prio_irq_ctrl (.*);

  always #4 clk = ~clk;

  // {irq[31:0], sw[31:0], req, vec[4:0], prio[1:0]}; line i has priority 3-(i%4), line 31 disabled
  localparam logic [71:0] TBL [8] = '{
    {32'h0000_0001, 32'h0, 1'b1, 5'd0,  2'd3},
    {32'h0000_0012, 32'h0, 1'b1, 5'd1,  2'd2},
    {32'h0000_0088, 32'h0, 1'b1, 5'd3,  2'd0},
    {32'h8000_0000, 32'h0, 1'b0, 5'd0,  2'd0},
    {32'h0000_0000, 32'h0000_0400, 1'b1, 5'd10, 2'd1},
    {32'h0000_0100, 32'h0000_0020, 1'b1, 5'd5,  2'd2},
    {32'h8000_0800, 32'h0, 1'b1, 5'd11, 2'd0},
    {32'h0000_0000, 32'h0, 1'b0, 5'd0,  2'd0}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic restart();
    irq_in = '0; sw_set_wr = 0; ack = 0; eos = 0;
    rst_n = 0; tick(); rst_n = 1;
    en_wr = 1; en_wdata = 32'h7FFF_FFFF; tick(); en_wr = 0;
    for (int i = 0; i < 32; i++) begin
      prio_wr = 1; prio_sel = 5'(i); prio_wdata = 2'(3 - (i % 4)); tick();
    end
    prio_wr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 req after reset", irq_req, 0);
    chk("R1 mask after reset", mask_lvl, 4);
    rst_n = 1;
    irq_in = 32'h1; tick();
    chk("R1 R2 disabled at reset", irq_req, 0);

    for (int r = 0; r < 8; r++) begin
      restart();
      irq_in = TBL[r][71:40]; sw_set_mask = TBL[r][39:8]; sw_set_wr = 1;
      tick(); sw_set_wr = 0;
      chk("R2 R3 R5 table req", irq_req, int'(TBL[r][7]));
      if (TBL[r][7]) begin
        chk("R3 table vec", irq_vec, int'(TBL[r][6:2]));
        chk("R3 table prio", irq_prio, int'(TBL[r][1:0]));
      end
    end

    // R2: disabled line latches pending, offered once enabled
    restart();
    irq_in = 32'h8000_0000; tick(); irq_in = '0; tick();
    chk("R2 disabled hidden", irq_req, 0);
    en_wr = 1; en_wdata = '1; tick(); en_wr = 0;
    chk("R2 enabled req", irq_req, 1);
    chk("R2 enabled vec", irq_vec, 31);

    // Nested service: R4 R6 R7 R8
    restart();
    irq_in = 32'h1; tick();
    chk("R6 first offer vec", irq_vec, 0);
    ack = 1; tick(); ack = 0;
    chk("R6 mask after ack", mask_lvl, 3);
    chk("R6 no repend in service", irq_req, 0);
    irq_in = 32'h15; tick();
    chk("R4 preempt vec", irq_vec, 2);
    ack = 1; tick(); ack = 0;
    chk("R6 nested mask", mask_lvl, 1);
    chk("R4 equal level p3 hidden", irq_req, 0);
    irq_in = 32'h55; tick();
    chk("R4 equal level hidden", irq_req, 0);
    eos = 1; tick(); eos = 0;
    chk("R7 restored mask", mask_lvl, 3);
    chk("R8 not yet repended vec", irq_vec, 6);
    tick();
    chk("R8 repend vec", irq_vec, 2);
    irq_in = '0;
    eos = 1; tick(); eos = 0;
    chk("R7 stack empty mask", mask_lvl, 4);
    eos = 1; tick(); eos = 0;
    chk("R7 eos on empty", mask_lvl, 4);

    // R9
    restart();
    ack = 1; tick(); ack = 0;
    chk("R9 ack idle mask", mask_lvl, 4);
    sw_set_mask = 32'h8; sw_set_wr = 1; tick(); sw_set_wr = 0;
    chk("R5 sw pend vec", irq_vec, 3);
    ack = 1; eos = 1; tick(); ack = 0; eos = 0;
    chk("R9 eos wins mask", mask_lvl, 4);
    chk("R9 eos wins req", irq_req, 1);
    ack = 1; tick(); ack = 0;
    chk("R6 sw ack mask", mask_lvl, 0);
    chk("R6 sw pend cleared", irq_req, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule